// File: doc/BRIEF.md
# Multi-thread gate control scheduler

This block is a time-aware egress gate scheduler. One table of gate-control entries is shared among up to eight cyclic execution threads. Each thread owns a contiguous slice of the table, given by a start address and an end index, and has its own start offset measured in delta units. Each table entry holds four things: a duration in deltas, a destination port mask, a per-traffic-class blocking mask, and window open/close flags with a shared flow index.

The scheduler is loaded while it is stopped. A start command then arms it, latching the operational start time and the number of active threads. Each enabled thread begins at the first delta strobe on which the current time reaches the start time plus that thread's offset. From then on it holds each entry for the entry's duration, steps to the next entry, and wraps at its end index on its own schedule. A stop command idles every thread at once and reopens all gates. The timebase supplies the delta strobe and the current time, both counted in deltas; one delta is nominally 200 ns.

Top module: `gate_sched`

## Requirements
- R1: After reset, stopped_o is 1. running_o, wr_err_o and every thread output are 0.
- R2: A start command is accepted only while stopped and only when stop_i is low. stopped_o is 0 in the cycle after it is accepted. Asserting start_i and stop_i together has no effect.
- R3: An accepted start latches base_time_i and act_m1_i. Thread t is enabled when t <= the latched act_m1_i. An enabled thread begins at the first delta_tick_i on which now_i >= latched base + its offset. It begins on its configured entry address.
- R4: An active thread holds each entry for exactly dur delta ticks, then steps to the next index. After its end index it wraps back to its start address.
- R5: A thread above the latched active count never becomes active. A thread whose offset is 0 never becomes active.
- R6: running_o is 1 in the cycle after any thread is active while started, and stays 1 until a stop. stopped_o is 1 only while stopped. The two are never both 1.
- R7: While thread t is active, its outputs show the fields of its current entry:
  - gate bit c = 1 means traffic class c is blocked;
  - the port mask;
  - the window-start flag, the window-end flag and the shared index.
  While thread t is inactive, all of its outputs are 0.
- R8: A stop (stop_i with start_i low, while started) makes every thread inactive in the next cycle. All gate vectors are 0 and stopped_o is 1 from that cycle on.
- R9: A table or thread-config write while not stopped is discarded, and wr_err_o is set.
- R10: A table write whose duration is 0 or at least MAX_DUR is discarded, and wr_err_o is set.
- R11: wr_err_o stays set until the next accepted start, which clears it.
- R12: Thread position and activity change only on a delta_tick_i cycle or on a stop. A change of now_i without a strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| delta_tick_i | input | 1 | One-cycle strobe per elapsed delta |
| now_i | input | TIME_W | Current time in deltas |
| base_time_i | input | TIME_W | Operational start time, latched at start |
| act_m1_i | input | TW | Active thread count minus one, latched at start |
| start_i | input | 1 | Start command |
| stop_i | input | 1 | Stop command |
| tbl_we_i | input | 1 | Table entry write |
| tbl_addr_i | input | AW | Entry address |
| tbl_dur_i | input | DUR_W | Entry duration in deltas |
| tbl_gate_i | input | NUM_TC | Blocked-class mask |
| tbl_ports_i | input | NUM_PORTS | Destination port mask |
| tbl_wstart_i | input | 1 | Window-start flag |
| tbl_wend_i | input | 1 | Window-end flag |
| tbl_share_i | input | SHARE_W | Shared flow index |
| cfg_we_i | input | 1 | Thread config write |
| cfg_sel_i | input | TW | Thread selected for config |
| cfg_off_i | input | OFF_W | Thread start offset in deltas |
| cfg_addr_i | input | AW | Thread first entry address |
| cfg_end_i | input | AW | Thread last entry index |
| thr_active_o | output | NT | Per-thread active |
| thr_idx_o | output | NT*AW | Per-thread current entry index |
| thr_gate_o | output | NT*NUM_TC | Per-thread blocked-class mask |
| thr_ports_o | output | NT*NUM_PORTS | Per-thread port mask |
| thr_wstart_o | output | NT | Per-thread window-start flag |
| thr_wend_o | output | NT | Per-thread window-end flag |
| thr_share_o | output | NT*SHARE_W | Per-thread shared index |
| running_o | output | 1 | Schedule started and executing |
| stopped_o | output | 1 | Schedule stopped |
| wr_err_o | output | 1 | Rejected write seen |

## Verification
A corrupted elapsed-count or index register shows up on thr_idx_o and thr_gate_o at the very next delta strobe, as an entry change that comes one strobe early or late. Because every thread wraps, the error then repeats on every cycle of that thread. A wrong start comparison moves a thread's first activity by one or more strobes. The per-strobe comparison against the arithmetic model catches this the moment it happens. A lost stop or a lost latch of the active count leaves a thread active, or gates blocked, in the cycle after the command.

// File: rtl/gsched_pkg.sv
package gsched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } run_state_e;
endpackage

// File: rtl/gsched_ctrl.sv
module gsched_ctrl #(
  parameter int TIME_W = 16,
  parameter int TW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [TIME_W-1:0] base_time_i,
  input  logic [TW-1:0]     act_m1_i,
  input  logic              any_active_i,
  input  logic              wr_bad_i,
  output logic              en_o,
  output logic              stop_acc_o,
  output logic [TIME_W-1:0] base_q_o,
  output logic [TW-1:0]     act_q_o,
  output logic              running_o,
  output logic              stopped_o,
  output logic              wr_err_o
);
  import gsched_pkg::*;

  run_state_e state_q;
  logic       start_acc;

  assign start_acc  = start_i & ~stop_i & (state_q == ST_IDLE);
  assign stop_acc_o = stop_i & ~start_i & (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      base_q_o <= '0;
      act_q_o  <= '0;
    end else if (stop_acc_o) begin
      state_q <= ST_IDLE;
    end else if (start_acc) begin
      state_q  <= ST_ARMED;
      base_q_o <= base_time_i;
      act_q_o  <= act_m1_i;
    end else if (state_q == ST_ARMED && any_active_i) begin
      state_q <= ST_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wr_err_o <= 1'b0;
    else if (wr_bad_i)  wr_err_o <= 1'b1;
    else if (start_acc) wr_err_o <= 1'b0;
  end

  assign en_o      = (state_q != ST_IDLE);
  assign running_o = (state_q == ST_RUN);
  assign stopped_o = (state_q == ST_IDLE);
endmodule

// File: rtl/gsched_table.sv
module gsched_table #(
  parameter int DEPTH     = 16,
  parameter int NT        = 8,
  parameter int DUR_W     = 7,
  parameter int MAX_DUR   = 100,
  parameter int NUM_TC    = 8,
  parameter int NUM_PORTS = 5,
  parameter int SHARE_W   = 4,
  parameter int OFF_W     = 8,
  parameter int AW        = 4,
  parameter int TW        = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    locked_i,
  input  logic                    tbl_we_i,
  input  logic [AW-1:0]           tbl_addr_i,
  input  logic [DUR_W-1:0]        tbl_dur_i,
  input  logic [NUM_TC-1:0]       tbl_gate_i,
  input  logic [NUM_PORTS-1:0]    tbl_ports_i,
  input  logic                    tbl_wstart_i,
  input  logic                    tbl_wend_i,
  input  logic [SHARE_W-1:0]      tbl_share_i,
  input  logic                    cfg_we_i,
  input  logic [TW-1:0]           cfg_sel_i,
  input  logic [OFF_W-1:0]        cfg_off_i,
  input  logic [AW-1:0]           cfg_addr_i,
  input  logic [AW-1:0]           cfg_end_i,
  input  logic [NT*AW-1:0]        rd_idx_i,
  output logic [NT*DUR_W-1:0]     rd_dur_o,
  output logic [NT*NUM_TC-1:0]    rd_gate_o,
  output logic [NT*NUM_PORTS-1:0] rd_ports_o,
  output logic [NT-1:0]           rd_wstart_o,
  output logic [NT-1:0]           rd_wend_o,
  output logic [NT*SHARE_W-1:0]   rd_share_o,
  output logic [NT*OFF_W-1:0]     off_o,
  output logic [NT*AW-1:0]        addr_o,
  output logic [NT*AW-1:0]        end_o,
  output logic                    bad_o
);
  logic [DUR_W-1:0]     dur_q   [DEPTH];
  logic [NUM_TC-1:0]    gate_q  [DEPTH];
  logic [NUM_PORTS-1:0] ports_q [DEPTH];
  logic [DEPTH-1:0]     ws_q, we_q;
  logic [SHARE_W-1:0]   share_q [DEPTH];
  logic [OFF_W-1:0]     off_q   [NT];
  logic [AW-1:0]        addr_q  [NT];
  logic [AW-1:0]        end_q   [NT];

  logic dur_ok, ent_ok, cfg_ok;

  assign dur_ok = (tbl_dur_i != '0) && (32'(tbl_dur_i) < MAX_DUR);
  assign ent_ok = tbl_we_i & ~locked_i & dur_ok;
  assign cfg_ok = cfg_we_i & ~locked_i;
  assign bad_o  = (tbl_we_i & (locked_i | ~dur_ok)) | (cfg_we_i & locked_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        dur_q[i]   <= '0;
        gate_q[i]  <= '0;
        ports_q[i] <= '0;
        share_q[i] <= '0;
      end
      ws_q <= '0;
      we_q <= '0;
      for (int i = 0; i < NT; i++) begin
        off_q[i]  <= '0;
        addr_q[i] <= '0;
        end_q[i]  <= '0;
      end
    end else begin
      if (ent_ok) begin
        dur_q[tbl_addr_i]   <= tbl_dur_i;
        gate_q[tbl_addr_i]  <= tbl_gate_i;
        ports_q[tbl_addr_i] <= tbl_ports_i;
        share_q[tbl_addr_i] <= tbl_share_i;
        ws_q[tbl_addr_i]    <= tbl_wstart_i;
        we_q[tbl_addr_i]    <= tbl_wend_i;
      end
      if (cfg_ok) begin
        off_q[cfg_sel_i]  <= cfg_off_i;
        addr_q[cfg_sel_i] <= cfg_addr_i;
        end_q[cfg_sel_i]  <= cfg_end_i;
      end
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_rd
    logic [AW-1:0] ix;
    assign ix = rd_idx_i[t*AW +: AW];
    assign rd_dur_o[t*DUR_W +: DUR_W]         = dur_q[ix];
    assign rd_gate_o[t*NUM_TC +: NUM_TC]      = gate_q[ix];
    assign rd_ports_o[t*NUM_PORTS +: NUM_PORTS] = ports_q[ix];
    assign rd_wstart_o[t]                     = ws_q[ix];
    assign rd_wend_o[t]                       = we_q[ix];
    assign rd_share_o[t*SHARE_W +: SHARE_W]   = share_q[ix];
    assign off_o[t*OFF_W +: OFF_W]            = off_q[t];
    assign addr_o[t*AW +: AW]                 = addr_q[t];
    assign end_o[t*AW +: AW]                  = end_q[t];
  end
endmodule

// File: rtl/gsched_thread.sv
module gsched_thread #(
  parameter int AW     = 4,
  parameter int DUR_W  = 7,
  parameter int OFF_W  = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              allow_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] now_i,
  input  logic [TIME_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [AW-1:0]     end_i,
  input  logic [DUR_W-1:0]  dur_i,
  output logic              active_o,
  output logic [AW-1:0]     idx_o
);
  logic [DUR_W-1:0] el_q;
  logic [TIME_W:0]  target;
  logic             due;

  // one extra bit so base+offset never wraps below now
  assign target = {1'b0, base_i} + (TIME_W+1)'(off_i);
  assign due    = allow_i && (off_i != '0) && ({1'b0, now_i} >= target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      idx_o    <= '0;
      el_q     <= '0;
    end else if (clr_i || !en_i) begin
      active_o <= 1'b0;
      idx_o    <= '0;
      el_q     <= '0;
    end else if (tick_i) begin
      if (!active_o) begin
        if (due) begin
          active_o <= 1'b1;
          idx_o    <= addr_i;
          el_q     <= '0;
        end
      end else if (DUR_W'(el_q + 1'b1) == dur_i) begin
        el_q  <= '0;
        idx_o <= (idx_o == end_i) ? addr_i : AW'(idx_o + 1'b1);
      end else begin
        el_q <= DUR_W'(el_q + 1'b1);
      end
    end
  end
endmodule

// File: rtl/gate_sched.sv
module gate_sched #(
  parameter int NUM_THREADS = 8,
  parameter int TABLE_DEPTH = 16,
  parameter int NUM_TC      = 8,
  parameter int NUM_PORTS   = 5,
  parameter int DUR_W       = 7,
  parameter int MAX_DUR     = 100,
  parameter int OFF_W       = 8,
  parameter int TIME_W      = 16,
  parameter int SHARE_W     = 4,
  parameter int AW          = $clog2(TABLE_DEPTH),
  parameter int TW          = $clog2(NUM_THREADS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             delta_tick_i,
  input  logic [TIME_W-1:0]                now_i,
  input  logic [TIME_W-1:0]                base_time_i,
  input  logic [TW-1:0]                    act_m1_i,
  input  logic                             start_i,
  input  logic                             stop_i,
  input  logic                             tbl_we_i,
  input  logic [AW-1:0]                    tbl_addr_i,
  input  logic [DUR_W-1:0]                 tbl_dur_i,
  input  logic [NUM_TC-1:0]                tbl_gate_i,
  input  logic [NUM_PORTS-1:0]             tbl_ports_i,
  input  logic                             tbl_wstart_i,
  input  logic                             tbl_wend_i,
  input  logic [SHARE_W-1:0]               tbl_share_i,
  input  logic                             cfg_we_i,
  input  logic [TW-1:0]                    cfg_sel_i,
  input  logic [OFF_W-1:0]                 cfg_off_i,
  input  logic [AW-1:0]                    cfg_addr_i,
  input  logic [AW-1:0]                    cfg_end_i,
  output logic [NUM_THREADS-1:0]           thr_active_o,
  output logic [NUM_THREADS*AW-1:0]        thr_idx_o,
  output logic [NUM_THREADS*NUM_TC-1:0]    thr_gate_o,
  output logic [NUM_THREADS*NUM_PORTS-1:0] thr_ports_o,
  output logic [NUM_THREADS-1:0]           thr_wstart_o,
  output logic [NUM_THREADS-1:0]           thr_wend_o,
  output logic [NUM_THREADS*SHARE_W-1:0]   thr_share_o,
  output logic                             running_o,
  output logic                             stopped_o,
  output logic                             wr_err_o
);
  localparam int NT = NUM_THREADS;

  logic              en, stop_acc, wr_bad;
  logic [TIME_W-1:0] base_q;
  logic [TW-1:0]     act_q;
  logic [NT-1:0]     act_v;
  logic [NT*AW-1:0]  idx_v;

  logic [NT*DUR_W-1:0]     rd_dur;
  logic [NT*NUM_TC-1:0]    rd_gate;
  logic [NT*NUM_PORTS-1:0] rd_ports;
  logic [NT-1:0]           rd_ws, rd_we;
  logic [NT*SHARE_W-1:0]   rd_share;
  logic [NT*OFF_W-1:0]     c_off;
  logic [NT*AW-1:0]        c_addr, c_end;

  gsched_ctrl #(.TIME_W(TIME_W), .TW(TW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .base_time_i, .act_m1_i,
    .any_active_i(|act_v), .wr_bad_i(wr_bad),
    .en_o(en), .stop_acc_o(stop_acc), .base_q_o(base_q), .act_q_o(act_q),
    .running_o, .stopped_o, .wr_err_o
  );

  gsched_table #(
    .DEPTH(TABLE_DEPTH), .NT(NT), .DUR_W(DUR_W), .MAX_DUR(MAX_DUR),
    .NUM_TC(NUM_TC), .NUM_PORTS(NUM_PORTS), .SHARE_W(SHARE_W),
    .OFF_W(OFF_W), .AW(AW), .TW(TW)
  ) u_tbl (
    .clk_i, .rst_ni, .locked_i(en),
    .tbl_we_i, .tbl_addr_i, .tbl_dur_i, .tbl_gate_i, .tbl_ports_i,
    .tbl_wstart_i, .tbl_wend_i, .tbl_share_i,
    .cfg_we_i, .cfg_sel_i, .cfg_off_i, .cfg_addr_i, .cfg_end_i,
    .rd_idx_i(idx_v), .rd_dur_o(rd_dur), .rd_gate_o(rd_gate),
    .rd_ports_o(rd_ports), .rd_wstart_o(rd_ws), .rd_wend_o(rd_we),
    .rd_share_o(rd_share), .off_o(c_off), .addr_o(c_addr), .end_o(c_end),
    .bad_o(wr_bad)
  );

  for (genvar t = 0; t < NT; t++) begin : g_thr
    gsched_thread #(.AW(AW), .DUR_W(DUR_W), .OFF_W(OFF_W), .TIME_W(TIME_W)) u_thr (
      .clk_i, .rst_ni, .en_i(en), .clr_i(stop_acc),
      .allow_i(TW'(t) <= act_q), .tick_i(delta_tick_i),
      .now_i, .base_i(base_q),
      .off_i(c_off[t*OFF_W +: OFF_W]),
      .addr_i(c_addr[t*AW +: AW]),
      .end_i(c_end[t*AW +: AW]),
      .dur_i(rd_dur[t*DUR_W +: DUR_W]),
      .active_o(act_v[t]),
      .idx_o(idx_v[t*AW +: AW])
    );

    assign thr_idx_o[t*AW +: AW]       = act_v[t] ? idx_v[t*AW +: AW] : '0;
    assign thr_gate_o[t*NUM_TC +: NUM_TC] =
      act_v[t] ? rd_gate[t*NUM_TC +: NUM_TC] : '0;
    assign thr_ports_o[t*NUM_PORTS +: NUM_PORTS] =
      act_v[t] ? rd_ports[t*NUM_PORTS +: NUM_PORTS] : '0;
    assign thr_wstart_o[t] = act_v[t] & rd_ws[t];
    assign thr_wend_o[t]   = act_v[t] & rd_we[t];
    assign thr_share_o[t*SHARE_W +: SHARE_W] =
      act_v[t] ? rd_share[t*SHARE_W +: SHARE_W] : '0;
  end

  assign thr_active_o = act_v;
endmodule

// File: rtl/gate_sched_chk.sv
module gate_sched_chk #(
  parameter int NT     = 8,
  parameter int AW     = 4,
  parameter int NUM_TC = 8,
  parameter int TW     = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             stop_i,
  input logic             delta_tick_i,
  input logic             tbl_we_i,
  input logic             cfg_we_i,
  input logic [NT-1:0]    thr_active_o,
  input logic [NT*AW-1:0] thr_idx_o,
  input logic [NT*NUM_TC-1:0] thr_gate_o,
  input logic             running_o,
  input logic             stopped_o,
  input logic             wr_err_o,
  input logic [TW-1:0]    act_q
);
  a_r6_status_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(running_o && stopped_o));

  a_r6_running_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|thr_active_o && !stop_i) |=> running_o);

  a_r2_start_leaves_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && stopped_o) |=> !stopped_o);

  a_r8_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i && !stopped_o) |=>
      (thr_active_o == '0 && thr_gate_o == '0 && stopped_o));

  a_r9_locked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tbl_we_i || cfg_we_i) && !stopped_o) |=> wr_err_o);

  a_r12_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!delta_tick_i && !stop_i) |=> ($stable(thr_idx_o) && $stable(thr_active_o)));

  for (genvar t = 0; t < NT; t++) begin : g_unused
    a_r5_unused_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (TW'(t) > act_q) |-> !thr_active_o[t]);
  end
endmodule

bind gate_sched gate_sched_chk #(
  .NT(NUM_THREADS), .AW(AW), .NUM_TC(NUM_TC), .TW(TW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .delta_tick_i(delta_tick_i), .tbl_we_i(tbl_we_i), .cfg_we_i(cfg_we_i),
  .thr_active_o(thr_active_o), .thr_idx_o(thr_idx_o), .thr_gate_o(thr_gate_o),
  .running_o(running_o), .stopped_o(stopped_o), .wr_err_o(wr_err_o),
  .act_q(act_q)
);

// File: tb/tb_gate_sched.sv
module tb_gate_sched;
  localparam int NT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] now = '0;
  logic [15:0] base = '0;
  logic [2:0]  act_m1 = '0;
  logic        start = 1'b0, stop = 1'b0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_addr = '0;
  logic [6:0]  tbl_dur = '0;
  logic [7:0]  tbl_gate = '0;
  logic [4:0]  tbl_ports = '0;
  logic        tbl_ws = 1'b0, tbl_wend = 1'b0;
  logic [3:0]  tbl_share = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_off = '0;
  logic [3:0]  cfg_addr = '0, cfg_end = '0;

  logic [NT-1:0]   act_o;
  logic [NT*4-1:0] idx_o;
  logic [NT*8-1:0] gate_o;
  logic [NT*5-1:0] ports_o;
  logic [NT-1:0]   ws_o, we_o;
  logic [NT*4-1:0] share_o;
  logic            running, stopped, wr_err;

  gate_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .delta_tick_i(tick), .now_i(now),
    .base_time_i(base), .act_m1_i(act_m1), .start_i(start), .stop_i(stop),
    .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_dur_i(tbl_dur),
    .tbl_gate_i(tbl_gate), .tbl_ports_i(tbl_ports), .tbl_wstart_i(tbl_ws),
    .tbl_wend_i(tbl_wend), .tbl_share_i(tbl_share),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_off_i(cfg_off),
    .cfg_addr_i(cfg_addr), .cfg_end_i(cfg_end),
    .thr_active_o(act_o), .thr_idx_o(idx_o), .thr_gate_o(gate_o),
    .thr_ports_o(ports_o), .thr_wstart_o(ws_o), .thr_wend_o(we_o),
    .thr_share_o(share_o), .running_o(running), .stopped_o(stopped),
    .wr_err_o(wr_err)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int e_dur [16];
  int c_off [NT], c_addr [NT], c_end [NT];

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic logic [7:0] g_of(int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  function automatic logic [23:0] exp_vec(int t, int n, int b, int a);
    int s, len, p, k;
    if (t > a || c_off[t] == 0) return '0;
    s = b + c_off[t];
    if (n < s) return '0;
    len = 0;
    for (int i = c_addr[t]; i <= c_end[t]; i++) len += e_dur[i];
    p = (n - s) % len;
    k = c_addr[t];
    while (p >= e_dur[k]) begin p -= e_dur[k]; k++; end
    return {1'b1, 4'(k), g_of(k), 5'(1 << (k % 5)), 1'(k & 1), 1'(~k & 1), 4'(k)};
  endfunction

  function automatic logic [23:0] act_vec(int t);
    return {act_o[t], idx_o[t*4 +: 4], gate_o[t*8 +: 8], ports_o[t*5 +: 5],
            ws_o[t], we_o[t], share_o[t*4 +: 4]};
  endfunction

  task automatic wr_ent(input int k, input int d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'(k); tbl_dur = 7'(d); tbl_gate = g_of(k);
    tbl_ports = 5'(1 << (k % 5)); tbl_ws = 1'(k & 1); tbl_wend = 1'(~k & 1);
    tbl_share = 4'(k);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic wr_cfg(input int t, input int o, input int a, input int e);
    c_off[t] = o; c_addr[t] = a; c_end[t] = e;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(t); cfg_off = 8'(o); cfg_addr = 4'(a); cfg_end = 4'(e);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_tick(input int n);
    @(negedge clk);
    now = 16'(n); tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_threads(input int n, input int b, input int a);
    bit any = 1'b0;
    for (int t = 0; t < NT; t++) begin
      logic [23:0] ev;
      ev = exp_vec(t, n, b, a);
      any |= ev[23];
      if (t > a || c_off[t] == 0) chk(act_vec(t) == ev, "R5 idle thread", 32'(act_vec(t)), 32'(ev));
      else chk(act_vec(t) == ev, "R3 R4 R7 thread state", 32'(act_vec(t)), 32'(ev));
    end
    chk(running == any, "R6 running", 32'(running), 32'(any));
  endtask

  task automatic do_start(input int b, input int a);
    @(negedge clk);
    base = 16'(b); act_m1 = 3'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) e_dur[i] = 1;
    e_dur[0] = 1; e_dur[1] = 2; e_dur[2] = 3; e_dur[3] = 2; e_dur[4] = 2; e_dur[5] = 4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(stopped == 1'b1, "R1 stopped", 32'(stopped), 1);
    chk(running == 1'b0, "R1 running", 32'(running), 0);
    chk(wr_err == 1'b0, "R1 err", 32'(wr_err), 0);
    chk(act_o == '0 && gate_o == '0, "R1 outputs", 32'(act_o), 0);

    for (int k = 0; k < 16; k++) wr_ent(k, e_dur[k]);
    wr_cfg(0, 1, 0, 2);
    wr_cfg(1, 3, 3, 4);
    wr_cfg(2, 2, 5, 5);
    for (int t = 3; t < NT; t++) wr_cfg(t, 1, 5, 5);
    chk(wr_err == 1'b0, "R9 legal writes", 32'(wr_err), 0);

    // R10: bad durations rejected
    wr_ent(2, 0);
    chk(wr_err == 1'b1, "R10 zero duration", 32'(wr_err), 1);
    wr_ent(2, 100);
    chk(wr_err == 1'b1, "R10 max duration", 32'(wr_err), 1);

    // R2: start with stop together is ignored
    @(negedge clk);
    start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk(stopped == 1'b1, "R2 start+stop ignored", 32'(stopped), 1);

    do_start(10, 2);
    chk(stopped == 1'b0, "R2 started", 32'(stopped), 0);
    chk(wr_err == 1'b0, "R11 err cleared", 32'(wr_err), 0);

    // R12: time jump without strobe
    @(negedge clk);
    now = 16'd1000;
    repeat (3) @(negedge clk);
    chk(act_o == '0, "R12 no strobe", 32'(act_o), 0);

    for (int n = 0; n <= 40; n++) begin
      do_tick(n);
      check_threads(n, 10, 2);
      if (n == 20) begin
        wr_ent(1, 5);
        chk(wr_err == 1'b1, "R9 write while running", 32'(wr_err), 1);
        wr_cfg(0, 7, 1, 1);
        c_off[0] = 1; c_addr[0] = 0; c_end[0] = 2;
        chk(wr_err == 1'b1, "R9 cfg while running", 32'(wr_err), 1);
      end
    end

    // R8: stop
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(act_o == '0, "R8 threads idle", 32'(act_o), 0);
    chk(gate_o == '0, "R8 gates open", gate_o[31:0], 0);
    chk(stopped == 1'b1 && running == 1'b0, "R8 status", {running, stopped}, 1);

    // second run: zero offset on thread 3, four threads enabled
    wr_cfg(3, 0, 5, 5);
    do_start(5, 3);
    chk(wr_err == 1'b0, "R11 err cleared again", 32'(wr_err), 0);
    for (int n = 0; n <= 24; n++) begin
      do_tick(n);
      check_threads(n, 5, 3);
    end
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(act_o == '0 && stopped == 1'b1, "R8 second stop", 32'(act_o), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule